// File: doc/BRIEF.md
# Banked Memory Window Address Mapper

This block sits between the 16-bit address bus of a small 8-bit processor and a 19-bit external address space. Software programs two windows, each with a size, an aligned base and a bank number. While the CPU address falls inside a window, the bank number replaces the upper address bits, which yields the expanded lines XA[18:13]. Outside every window, XA[18:16] is zero and XA[15:13] follows the CPU address. For each access the block also reports which resource answers: the register block, RAM, EEPROM, on-chip ROM or external memory.

Internal registers, RAM and EEPROM are decoded from the CPU address alone, so they answer in every bank of a window that covers them. On-chip ROM answers only when XA[18:16] is zero. During the reset vector fetch, the block chooses between ROM, an external fetch at the top of memory and an external fetch at $7FFE, depending on the expansion and ROM settings. Six port pins each carry either a general-purpose I/O signal or one expanded address line.

Top module: `mmap_xlate`

## Requirements
- R1: After reset every register reads 0, both windows are off and every pin follows its GPIO value and GPIO enable.
- R2: Register addresses: 0 holds the pin assignment in bits 5:0. 1 holds the window 1 size in bits 1:0 and the window 2 size in bits 3:2. 2 holds the window 1 base in bits 2:0 and the window 2 base in bits 6:4. 3 and 4 hold the window 1 and window 2 banks in bits 5:0. Unimplemented bits and addresses 5 to 7 read 0.
- R3: Size codes are 00 off, 01 8 KB, 10 16 KB and 11 32 KB. A window matches when the CPU A[15:13] equals the base on the bits above the window size. Inside a window, XA[18:13] takes bank bits down to the window boundary and CPU address bits below it.
- R4: When both windows match an address, window 1 supplies XA.
- R5: Outside every window, XA[18:13] = {000, A[15:13]}.
- R6: Registers ($0000-$007F), RAM ($0080-$037F) and EEPROM ($0D80-$0FFF) are decoded from the CPU address, in that priority, whatever the XA value. Region codes: 0 registers, 1 RAM, 2 EEPROM, 3 ROM, 4 external.
- R7: ROM ($A000-$FFFF, or $2000-$7FFF when the low-map input is set) answers only when it is enabled and XA[18:16] = 000. Otherwise the access goes to external memory.
- R8: On a vector fetch with expansion enabled, the region is external and XA[18:13] = 000011, which selects $7FFE.
- R9: On a vector fetch with expansion disabled, XA[18:13] = 000111. The region is ROM only if ROM is enabled and not low-mapped; otherwise it is external.
- R10: A pin whose assignment bit is 0 drives its GPIO value and enable. A pin assigned to address line XA[13+k] that some enabled window uses drives that XA bit, with its output enable set.
- R11: Pins 3 to 5 (XA[18:16]) that are assigned but unused by both windows stay GPIO.
- R12: Pins 0 to 2 (XA[15:13]) that are assigned but unused by both windows drive CPU A[13+k], with the output enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data |
| addr | input | 16 | CPU address |
| vec_fetch | input | 1 | CPU is fetching the reset vector |
| xmem_en | input | 1 | Expanded memory enabled |
| rom_en | input | 1 | On-chip ROM enabled |
| rom_low | input | 1 | ROM mapped at $2000-$7FFF |
| gpio_do | input | 6 | GPIO output values for the six pins |
| gpio_oe | input | 6 | GPIO output enables for the six pins |
| xa_hi | output | 6 | Expanded address XA[18:13] |
| region | output | 3 | Responding resource code |
| pin_out | output | 6 | Pin output values |
| pin_oe | output | 6 | Pin output enables |

## Verification
The bench aims at a ROM address placed in a non-zero bank, which a design that ignored the bank would wrongly send to ROM. It also checks register and RAM addresses inside a bank, where a design that decoded from XA would lose the internal resource. Overlapping windows expose a reversed priority, and the three reset-vector cases catch a design that ignores the expansion setting or the low ROM mapping. The pin tests cover assigned but unused lines. A wrong design would let the upper pins float as address lines, or drop CPU A[15:13] from the lower pins.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  localparam int NWIN = 2;
  localparam int XW   = 6;   // XA[18:13]
  localparam int PASS_PINS = 3; // pins carrying XA[15:13]

  typedef enum logic [2:0] {
    RG_REGS = 3'd0,
    RG_RAM  = 3'd1,
    RG_EE   = 3'd2,
    RG_ROM  = 3'd3,
    RG_EXT  = 3'd4
  } region_e;

  typedef enum logic [1:0] {
    SZ_OFF = 2'b00,
    SZ_8K  = 2'b01,
    SZ_16K = 2'b10,
    SZ_32K = 2'b11
  } win_size_e;
endpackage

// File: rtl/mmap_regs.sv
module mmap_regs
  import mmap_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [2:0]                wr_addr,
  input  logic [7:0]                wr_data,
  input  logic [2:0]                rd_addr,
  output logic [7:0]                rd_data,
  output logic [XW-1:0]             pga,
  output logic [NWIN-1:0][1:0]      win_size,
  output logic [NWIN-1:0][2:0]      win_base,
  output logic [NWIN-1:0][XW-1:0]   win_bank
);
  logic [XW-1:0]           pga_d;
  logic [NWIN-1:0][1:0]    size_d;
  logic [NWIN-1:0][2:0]    base_d;
  logic [NWIN-1:0][XW-1:0] bank_d;

  always_comb begin
    pga_d  = pga;
    size_d = win_size;
    base_d = win_base;
    bank_d = win_bank;
    case (wr_addr)
      3'd0: pga_d = wr_data[XW-1:0];
      3'd1: size_d = {wr_data[3:2], wr_data[1:0]};
      3'd2: base_d = {wr_data[6:4], wr_data[2:0]};
      3'd3: bank_d[0] = wr_data[XW-1:0];
      3'd4: bank_d[1] = wr_data[XW-1:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pga      <= '0;
      win_size <= '0;
      win_base <= '0;
      win_bank <= '0;
    end else if (wr_en) begin
      pga      <= pga_d;
      win_size <= size_d;
      win_base <= base_d;
      win_bank <= bank_d;
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = {2'b00, pga};
      3'd1:    rd_data = {4'b0000, win_size[1], win_size[0]};
      3'd2:    rd_data = {1'b0, win_base[1], 1'b0, win_base[0]};
      3'd3:    rd_data = {2'b00, win_bank[0]};
      3'd4:    rd_data = {2'b00, win_bank[1]};
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/mmap_window.sv
module mmap_window
  import mmap_pkg::*;
(
  input  logic [1:0]    size,
  input  logic [2:0]    base,
  input  logic [XW-1:0] bank,
  input  logic [2:0]    a_hi,    // CPU A[15:13]
  output logic          hit,
  output logic [XW-1:0] xa,
  output logic [XW-1:0] used
);
  always_comb begin
    case (win_size_e'(size))
      SZ_8K: begin
        hit  = (a_hi == base);
        xa   = bank;
        used = 6'b111111;
      end
      SZ_16K: begin
        hit  = (a_hi[2:1] == base[2:1]);
        xa   = {bank[5:1], a_hi[0]};
        used = 6'b111110;
      end
      SZ_32K: begin
        hit  = (a_hi[2] == base[2]);
        xa   = {bank[5:2], a_hi[1:0]};
        used = 6'b111100;
      end
      default: begin
        hit  = 1'b0;
        xa   = {3'b000, a_hi};
        used = 6'b000000;
      end
    endcase
  end
endmodule

// File: rtl/mmap_pins.sv
module mmap_pins
  import mmap_pkg::*;
(
  input  logic [XW-1:0] pga,
  input  logic [XW-1:0] used,
  input  logic [XW-1:0] xa,
  input  logic [XW-1:0] gpio_do,
  input  logic [XW-1:0] gpio_oe,
  output logic [XW-1:0] pin_out,
  output logic [XW-1:0] pin_oe
);
  for (genvar k = 0; k < XW; k++) begin : g_pin
    logic addr_mode;
    if (k < PASS_PINS) begin : g_pass
      // lower lines still carry the CPU address when no window claims them
      assign addr_mode = pga[k];
    end else begin : g_bank
      assign addr_mode = pga[k] & used[k];
    end
    assign pin_out[k] = addr_mode ? xa[k] : gpio_do[k];
    assign pin_oe[k]  = addr_mode ? 1'b1  : gpio_oe[k];
  end
endmodule

// File: rtl/mmap_xlate.sv
module mmap_xlate
  import mmap_pkg::*;
#(
  parameter logic [15:0] REG_BASE    = 16'h0000,
  parameter int          REG_SIZE    = 128,
  parameter logic [15:0] RAM_BASE    = 16'h0080,
  parameter int          RAM_SIZE    = 768,
  parameter logic [15:0] EE_BASE     = 16'h0D80,
  parameter int          EE_SIZE     = 640,
  parameter logic [15:0] ROM_HI_BASE = 16'hA000,
  parameter logic [15:0] ROM_LO_BASE = 16'h2000,
  parameter logic [15:0] ROM_LO_LAST = 16'h7FFF,
  parameter logic [5:0]  VEC_XMEM_XA = 6'b000011,
  parameter logic [5:0]  VEC_TOP_XA  = 6'b000111
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [7:0]   wr_data,
  input  logic [2:0]   rd_addr,
  output logic [7:0]   rd_data,
  input  logic [15:0]  addr,
  input  logic         vec_fetch,
  input  logic         xmem_en,
  input  logic         rom_en,
  input  logic         rom_low,
  input  logic [5:0]   gpio_do,
  input  logic [5:0]   gpio_oe,
  output logic [5:0]   xa_hi,
  output logic [2:0]   region,
  output logic [5:0]   pin_out,
  output logic [5:0]   pin_oe
);
  localparam int REG_LO = int'(REG_BASE);
  localparam int REG_HI = REG_LO + REG_SIZE;
  localparam int RAM_LO = int'(RAM_BASE);
  localparam int RAM_HI = RAM_LO + RAM_SIZE;
  localparam int EE_LO  = int'(EE_BASE);
  localparam int EE_HI  = EE_LO + EE_SIZE;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic [XW-1:0]           pga;
  logic [NWIN-1:0][1:0]    win_size;
  logic [NWIN-1:0][2:0]    win_base;
  logic [NWIN-1:0][XW-1:0] win_bank;

  mmap_regs u_regs (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pga(pga), .win_size(win_size), .win_base(win_base), .win_bank(win_bank)
  );

  logic [NWIN-1:0]         hit;
  logic [NWIN-1:0][XW-1:0] wxa;
  logic [NWIN-1:0][XW-1:0] wused;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    mmap_window u_win (
      .size(win_size[w]), .base(win_base[w]), .bank(win_bank[w]),
      .a_hi(addr[15:13]), .hit(hit[w]), .xa(wxa[w]), .used(wused[w])
    );
  end

  logic [XW-1:0] xa_win;
  logic [XW-1:0] used_any;
  always_comb begin
    xa_win   = {3'b000, addr[15:13]};
    used_any = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      used_any = used_any | wused[i];
      if (hit[i]) xa_win = wxa[i];   // lowest index wins
    end
  end

  logic in_reg, in_ram, in_ee, in_rom;
  int   a_i;
  always_comb begin
    a_i    = int'({16'd0, addr});
    in_reg = (a_i >= REG_LO) && (a_i < REG_HI);
    in_ram = (a_i >= RAM_LO) && (a_i < RAM_HI);
    in_ee  = (a_i >= EE_LO)  && (a_i < EE_HI);
    in_rom = rom_en && (xa_win[5:3] == 3'b000) &&
             (rom_low ? ((addr >= ROM_LO_BASE) && (addr <= ROM_LO_LAST))
                      : (addr >= ROM_HI_BASE));
  end

  region_e rg;
  always_comb begin
    if (vec_fetch) begin
      if (xmem_en) begin
        xa_hi = VEC_XMEM_XA;
        rg    = RG_EXT;
      end else begin
        xa_hi = VEC_TOP_XA;
        rg    = (rom_en && !rom_low) ? RG_ROM : RG_EXT;
      end
    end else begin
      xa_hi = xa_win;
      if      (in_reg) rg = RG_REGS;
      else if (in_ram) rg = RG_RAM;
      else if (in_ee)  rg = RG_EE;
      else if (in_rom) rg = RG_ROM;
      else             rg = RG_EXT;
    end
  end
  assign region = rg;

  mmap_pins u_pins (
    .pga(pga), .used(used_any), .xa(xa_hi), .gpio_do(gpio_do),
    .gpio_oe(gpio_oe), .pin_out(pin_out), .pin_oe(pin_oe)
  );
endmodule

// File: rtl/mmap_xlate_chk.sv
module mmap_xlate_chk
  import mmap_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [7:0]    wr_data,
  input logic [15:0]   addr,
  input logic          vec_fetch,
  input logic          xmem_en,
  input logic [5:0]    gpio_oe,
  input logic [5:0]    pga,
  input logic [1:0]    hit,
  input logic [5:0]    bank0,
  input logic [5:0]    xa_hi,
  input logic [2:0]    region,
  input logic [5:0]    pin_oe
);
  // R2: a write to address 3 lands in the window 1 bank
  p_bank_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd3) |=> (bank0 == $past(wr_data[5:0])));

  // R5: no window and no vector fetch leaves the CPU bits in XA
  p_outside_xa_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == 2'b00 && !vec_fetch) |-> (xa_hi == {3'b000, addr[15:13]}));

  // R7: ROM only ever answers in bank 0
  p_rom_bank0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_ROM) |-> (xa_hi[5:3] == 3'b000));

  // R8: expanded vector fetch goes external at $7FFE
  p_vec_xmem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_fetch && xmem_en) |-> (region == RG_EXT && xa_hi == 6'b000011));

  // R10: unassigned pins keep the GPIO enable
  p_gpio_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (((pin_oe ^ gpio_oe) & ~pga) == 6'd0));
endmodule

bind mmap_xlate mmap_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .addr(addr), .vec_fetch(vec_fetch), .xmem_en(xmem_en),
  .gpio_oe(gpio_oe), .pga(pga), .hit(hit), .bank0(win_bank[0]),
  .xa_hi(xa_hi), .region(region), .pin_oe(pin_oe)
);

// File: tb/tb_mmap_xlate.sv
module tb_mmap_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [2:0]  rd_addr;
  logic [7:0]  rd_data;
  logic [15:0] addr;
  logic        vec_fetch, xmem_en, rom_en, rom_low;
  logic [5:0]  gpio_do, gpio_oe;
  logic [5:0]  xa_hi;
  logic [2:0]  region;
  logic [5:0]  pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  mmap_xlate dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .addr(addr),
    .vec_fetch(vec_fetch), .xmem_en(xmem_en), .rom_en(rom_en),
    .rom_low(rom_low), .gpio_do(gpio_do), .gpio_oe(gpio_oe), .xa_hi(xa_hi),
    .region(region), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {addr, vec/xmem/rom_en/rom_low, expected XA[18:13], expected region, pad}
  // window 1: 8 KB at $A000 bank 0x16; window 2: 32 KB at $0000 bank 0x04
  localparam logic [31:0] TV [13] = '{
    {16'hA123, 4'b0010, 6'h16, 3'd4, 3'd0},  // R3 8 KB bank, R7 ROM in bank 2 -> ext
    {16'h0040, 4'b0010, 6'h04, 3'd0, 3'd0},  // R6 registers inside bank
    {16'h0100, 4'b0010, 6'h04, 3'd1, 3'd0},  // R6 RAM inside bank
    {16'h0E00, 4'b0010, 6'h04, 3'd2, 3'd0},  // R6 EEPROM inside bank
    {16'h6123, 4'b0010, 6'h07, 3'd4, 3'd0},  // R3 32 KB passes A14:13
    {16'hC000, 4'b0010, 6'h06, 3'd3, 3'd0},  // R5 outside, R7 ROM bank 0
    {16'h8000, 4'b0010, 6'h04, 3'd4, 3'd0},  // R5 outside, below ROM
    {16'h3000, 4'b0011, 6'h05, 3'd3, 3'd0},  // R7 low-mapped ROM, XA18:16 = 000
    {16'hFFFE, 4'b1110, 6'h03, 3'd4, 3'd0},  // R8 expanded vector
    {16'hFFFE, 4'b1010, 6'h07, 3'd3, 3'd0},  // R9 vector from ROM
    {16'hFFFE, 4'b1000, 6'h07, 3'd4, 3'd0},  // R9 ROM disabled
    {16'hFFFE, 4'b1011, 6'h07, 3'd4, 3'd0},  // R9 ROM low-mapped
    {16'hBFFE, 4'b0010, 6'h16, 3'd4, 3'd0}   // R3 top of window 1
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    rd_addr = a;
    #2;
    check(tag, {24'd0, rd_data}, {24'd0, exp});
  endtask

  task automatic apply(input logic [15:0] a, input logic [3:0] ctl);
    @(negedge clk);
    addr = a;
    {vec_fetch, xmem_en, rom_en, rom_low} = ctl;
    #2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; addr = 0;
    vec_fetch = 0; xmem_en = 0; rom_en = 1; rom_low = 0;
    gpio_do = 6'b010101; gpio_oe = 6'b101010;
    do_reset();

    // R1: reset state
    for (int i = 0; i < 8; i++) rd(3'(i), 8'h00, "R1 reg reset");
    apply(16'hA000, 4'b0010);
    check("R1 pins out", {26'd0, pin_out}, 32'h15);
    check("R1 pins oe", {26'd0, pin_oe}, 32'h2A);
    check("R1 xa off", {26'd0, xa_hi}, 32'h05);

    // R2: register map and masks
    wr(3'd0, 8'hFF); rd(3'd0, 8'h3F, "R2 pin assign");
    wr(3'd1, 8'hFF); rd(3'd1, 8'h0F, "R2 sizes");
    wr(3'd2, 8'hFF); rd(3'd2, 8'h77, "R2 bases");
    wr(3'd3, 8'hFF); rd(3'd3, 8'h3F, "R2 bank1");
    wr(3'd4, 8'hFF); rd(3'd4, 8'h3F, "R2 bank2");
    wr(3'd5, 8'hFF); rd(3'd5, 8'h00, "R2 unused addr");

    // table configuration
    wr(3'd0, 8'h3F);
    wr(3'd1, 8'h0D);   // w1 8 KB, w2 32 KB
    wr(3'd2, 8'h05);   // w1 base 101, w2 base 000
    wr(3'd3, 8'h16);
    wr(3'd4, 8'h04);
    for (int i = 0; i < 13; i++) begin
      apply(TV[i][31:16], TV[i][15:12]);
      check($sformatf("table %0d xa", i), {26'd0, xa_hi}, {26'd0, TV[i][11:6]});
      check($sformatf("table %0d region", i), {29'd0, region}, {29'd0, TV[i][5:3]});
      check($sformatf("table %0d R10 pins", i), {26'd0, pin_out}, {26'd0, TV[i][11:6]});
      check($sformatf("table %0d R10 oe", i), {26'd0, pin_oe}, 32'h3F);
    end

    // R4: overlap, window 1 wins
    wr(3'd1, 8'h05); wr(3'd2, 8'h55); wr(3'd4, 8'h21);
    apply(16'hA000, 4'b0010);
    check("R4 priority", {26'd0, xa_hi}, 32'h16);
    wr(3'd1, 8'h04);
    apply(16'hA000, 4'b0010);
    check("R4 w2 alone xa", {26'd0, xa_hi}, 32'h21);
    check("R7 w2 bank4 ext", {29'd0, region}, 32'd4);
    wr(3'd1, 8'h00);
    apply(16'hA000, 4'b0010);
    check("R3 size off xa", {26'd0, xa_hi}, 32'h05);
    check("R3 size off rom", {29'd0, region}, 32'd3);

    // R11 / R12: all assigned, no window uses any line
    check("R12 pass pins", {26'd0, pin_out}, 32'h15);
    check("R11 upper gpio oe", {26'd0, pin_oe}, 32'h2F);

    // R10: nothing assigned
    wr(3'd0, 8'h00);
    apply(16'hA000, 4'b0010);
    check("R10 gpio out", {26'd0, pin_out}, 32'h15);
    check("R10 gpio oe", {26'd0, pin_oe}, 32'h2A);

    // mixed: w1 32 KB at $8000 bank 0x34, pins 0,4,5 assigned
    wr(3'd1, 8'h03); wr(3'd2, 8'h04); wr(3'd3, 8'h34); wr(3'd0, 8'h31);
    apply(16'hE000, 4'b0010);
    check("R3 32K xa", {26'd0, xa_hi}, 32'h37);
    check("R12 mixed out", {26'd0, pin_out}, 32'h35);
    check("R10 mixed oe", {26'd0, pin_oe}, 32'h3B);
    check("R7 mixed ext", {29'd0, region}, 32'd4);

    // R1: reset mid-run clears the map
    do_reset();
    rd(3'd3, 8'h00, "R1 bank cleared");
    rd(3'd1, 8'h00, "R1 sizes cleared");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule